// File: doc/BRIEF.md
# Serial Transmitter with Break Generation

This block is the transmit half of an asynchronous serial port. Words enter through a register-style write port into a four-entry, nine-bit queue. A shift register behind the queue turns each word into an NRZ frame on a single output line, least significant bit first. One bit time is sixteen pulses of an external baud enable. The frame format is set by inputs: 8 or 9 data bits, even, odd or no parity, and one or two stop bits. A polarity control flips the whole line, including its idle level.

A break request turns the next word taken from the queue into a break character: a start bit, twelve zero bits and a stop bit. The value of that word is not used. The request clears itself when the break's stop bit ends, so a word queued behind it, usually a sync value, goes out straight after the break.

An interrupt pulse is raised in one of three selectable situations, and also when the transmitter is switched on. Dropping the enable aborts everything and returns the block to idle.

Top module: `uart_break_tx`

## Requirements
- R1: The queue holds 4 words of 9 bits, so with the shift register 5 words can be pending. A write while the queue holds 4 words is discarded, and a write while `tx_enable` is low is discarded.
- R2: `buf_full` is 1 exactly when the queue holds 4 words.
- R3: `shifter_empty` is 1 exactly when no frame is being shifted and the queue is empty.
- R4: A frame is a start bit (0), data bits 0..7 in that order, an optional parity bit and one stop bit (1), or two stop bits when `two_stop`=1. `parity_sel` 01 selects even parity (the ones in data plus parity form an even count), 10 selects odd parity, and 00 or 11 selects no parity bit. Each bit lasts 16 cycles in which `baud_tick` is 1.
- R5: With `nine_bit`=1 no parity bit is sent. Data bit 8 follows bit 7 and comes directly before the stop bit or bits.
- R6: A word written at a clock edge while the block is idle starts its start bit after the next edge. When a word is queued, its start bit begins in the cycle right after the previous stop bit ends, with no idle cycle between.
- R7: `tx_irq` is a one-cycle pulse selected by `irq_mode`. 00 pulses on every transfer from the queue to the shifter. 01 pulses when a frame ends with the queue empty. 10 pulses on a transfer that leaves the queue empty. 11 never pulses.
- R8: `tx_irq` pulses once in the cycle after `tx_enable` rises.
- R9: A `brk_set` pulse while enabled sets `brk_pending`. The next word moved into the shifter while it is set is sent as a start bit, twelve 0 bits and one stop bit (14 bit times). The word's value is ignored. `brk_pending` clears when that stop bit ends, and the next queued word follows as a normal frame.
- R10: `txd` equals the logical line XOR `invert`, so the idle level is 1 when `invert`=0 and 0 when `invert`=1.
- R11: One cycle with `tx_enable` low aborts the frame in progress, empties the queue, clears `buf_full` and `brk_pending`, sets `shifter_empty`, and returns `txd` to the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_enable | input | 1 | Transmitter on; low clears and aborts |
| invert | input | 1 | Invert the line polarity |
| nine_bit | input | 1 | Send 9 data bits without parity |
| parity_sel | input | 2 | 00/11 none, 01 even, 10 odd |
| two_stop | input | 1 | Two stop bits instead of one |
| irq_mode | input | 2 | Interrupt cause selector |
| brk_set | input | 1 | Pulse to request a break character |
| baud_tick | input | 1 | Baud enable, 16 per bit time |
| wr_valid | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 9 | Word to send |
| buf_full | output | 1 | Queue holds 4 words |
| shifter_empty | output | 1 | Nothing shifting and nothing queued |
| brk_pending | output | 1 | Break request not yet completed |
| tx_irq | output | 1 | Transmit interrupt pulse |
| txd | output | 1 | Serial output line |

## Verification
Two situations are hardest to reach from the ports. The first is the exact edge where a break's stop bit ends: at that edge the request must clear, and the word waiting behind it must load as a normal frame. The bench reaches it by issuing the break request, then writing the dummy word and the sync word on consecutive cycles. A concurrent monitor checks that the break and the sync frame sit back to back. The second is a full queue with a live shifter. A six-word burst fills the queue within six cycles, and the monitor checks that exactly five frames leave with no gap and that the sixth word is never sent.

// File: rtl/uart_tx_pkg.sv
// Package: shared encodings and frame sizing for the break-capable transmitter.
// Assumes 8 base data bits; the ninth bit replaces parity when selected.
package uart_tx_pkg;

    localparam int BASE_BITS   = 8;
    localparam int BREAK_ZEROS = 12;
    // Longest frame is the break: start + zeros + stop.
    localparam int FRAME_W     = BREAK_ZEROS + 2;

    typedef enum logic [1:0] {
        PAR_NONE  = 2'b00,
        PAR_EVEN  = 2'b01,
        PAR_ODD   = 2'b10,
        PAR_NONE2 = 2'b11
    } parity_e;

    typedef enum logic [1:0] {
        IRQ_EACH_LOAD = 2'b00,
        IRQ_DRAINED   = 2'b01,
        IRQ_LAST_LOAD = 2'b10,
        IRQ_OFF       = 2'b11
    } irq_mode_e;

endpackage

// File: rtl/tx_word_fifo.sv
// Module: tx_word_fifo
// Small first-in first-out queue of transmit words. A push while full is
// dropped. A pop while empty is ignored. Assumes clear is a synchronous flush.
module tx_word_fifo #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clear,
    input  logic                           push,
    input  logic [WIDTH-1:0]               din,
    input  logic                           pop,
    output logic [WIDTH-1:0]               dout,
    output logic                           full,
    output logic                           empty,
    output logic [$clog2(DEPTH+1)-1:0]     count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rd_ptr];

    // Storage write for accepted pushes.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= din;
        end
    end

    // Pointer and occupancy bookkeeping with flush.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_next(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    assert_drop_when_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clear) |=> (full && $stable(wr_ptr)));

endmodule

// File: rtl/tx_frame_shifter.sv
// Module: tx_frame_shifter
// Builds a whole frame as a bit vector at load time and shifts it out LSB
// first, one bit per TICKS_PER_BIT baud enables. A break load replaces the
// frame with start, zeros and stop. Assumes load arrives only when idle or
// together with finish.
module tx_frame_shifter
    import uart_tx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           baud_tick,
    input  logic           load,
    input  logic           load_brk,
    input  logic [8:0]     din,
    input  logic           nine_bit,
    input  logic [1:0]     parity_sel,
    input  logic           two_stop,
    output logic           busy,
    output logic           line,
    output logic           finish,
    output logic           cur_brk
);
    localparam int LEN_W  = $clog2(FRAME_W+1);
    localparam int TICK_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;

    logic [FRAME_W-1:0] shreg, frame_next;
    logic [LEN_W-1:0]   bits_left, len_next;
    logic [TICK_W-1:0]  tick_cnt;
    logic               bit_end;
    logic               extra, xbit;
    parity_e            par;

    assign par     = parity_e'(parity_sel);
    assign bit_end = busy && baud_tick && (tick_cnt == TICK_W'(TICKS_PER_BIT-1));
    assign finish  = bit_end && (bits_left == LEN_W'(1));
    assign line    = busy ? shreg[0] : 1'b1;

    // Assemble the frame vector and its length for the word being loaded.
    always_comb begin
        extra = 1'b0;
        xbit  = 1'b1;
        if (nine_bit) begin
            extra = 1'b1;
            xbit  = din[8];
        end else if (par == PAR_EVEN) begin
            extra = 1'b1;
            xbit  = ^din[BASE_BITS-1:0];
        end else if (par == PAR_ODD) begin
            extra = 1'b1;
            xbit  = ~^din[BASE_BITS-1:0];
        end
        frame_next              = '1;
        frame_next[0]           = 1'b0;
        frame_next[BASE_BITS:1] = din[BASE_BITS-1:0];
        frame_next[BASE_BITS+1] = extra ? xbit : 1'b1;
        len_next = LEN_W'(BASE_BITS + 2) + LEN_W'(extra) + LEN_W'(two_stop);
        if (load_brk) begin
            frame_next = {1'b1, {(FRAME_W-1){1'b0}}};
            len_next   = LEN_W'(FRAME_W);
        end
    end

    // Frame load, bit timing and shifting.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            shreg     <= '1;
            bits_left <= '0;
            tick_cnt  <= '0;
            busy      <= 1'b0;
            cur_brk   <= 1'b0;
        end else if (load) begin
            shreg     <= frame_next;
            bits_left <= len_next;
            tick_cnt  <= '0;
            busy      <= 1'b1;
            cur_brk   <= load_brk;
        end else if (bit_end) begin
            shreg     <= {1'b1, shreg[FRAME_W-1:1]};
            bits_left <= bits_left - LEN_W'(1);
            tick_cnt  <= '0;
            if (bits_left == LEN_W'(1)) begin
                busy    <= 1'b0;
                cur_brk <= 1'b0;
            end
        end else if (busy && baud_tick) begin
            tick_cnt <= tick_cnt + TICK_W'(1);
        end
    end

    assert_busy_has_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bits_left != '0));

    assert_no_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && load && !clear) |=> (busy && !line));

endmodule

// File: rtl/tx_irq_select.sv
// Module: tx_irq_select
// Picks the transmit interrupt cause from the mode input and registers a
// one-cycle pulse. The enable-rise cause is always active.
module tx_irq_select
    import uart_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] irq_mode,
    input  logic       en_rise,
    input  logic       load,
    input  logic       load_leaves_empty,
    input  logic       drained,
    output logic       irq
);
    irq_mode_e mode;
    logic      cause;

    assign mode = irq_mode_e'(irq_mode);

    // Select the active cause for the current mode.
    always_comb begin
        case (mode)
            IRQ_EACH_LOAD: cause = load;
            IRQ_DRAINED:   cause = drained;
            IRQ_LAST_LOAD: cause = load_leaves_empty;
            default:       cause = 1'b0;
        endcase
    end

    // Register the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= cause || en_rise;
    end

endmodule

// File: rtl/uart_break_tx.sv
// Module: uart_break_tx
// Serial transmitter top: queue, frame shifter, break request flag and
// interrupt selection. Assumes baud_tick is a one-cycle enable and that
// the format inputs change only while shifter_empty is high.
module uart_break_tx
    import uart_tx_pkg::*;
#(
    parameter int DEPTH         = 4,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_enable,
    input  logic       invert,
    input  logic       nine_bit,
    input  logic [1:0] parity_sel,
    input  logic       two_stop,
    input  logic [1:0] irq_mode,
    input  logic       brk_set,
    input  logic       baud_tick,
    input  logic       wr_valid,
    input  logic [8:0] wr_data,
    output logic       buf_full,
    output logic       shifter_empty,
    output logic       brk_pending,
    output logic       tx_irq,
    output logic       txd
);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic             clear, push, load, load_brk;
    logic             fifo_empty, busy, line, finish, cur_brk;
    logic [8:0]       head;
    logic [CNT_W-1:0] fifo_count;
    logic             en_prev, en_rise, brk_flag;
    logic             leaves_empty, drained;

    assign clear         = !tx_enable;
    assign push          = wr_valid && tx_enable;
    assign load          = tx_enable && !fifo_empty && (!busy || finish);
    assign load_brk      = brk_flag && !(finish && cur_brk);
    assign en_rise       = tx_enable && !en_prev;
    assign leaves_empty  = load && (fifo_count == CNT_W'(1)) && !(push && !buf_full);
    assign drained       = finish && fifo_empty;
    assign shifter_empty = !busy && fifo_empty;
    assign brk_pending   = brk_flag;
    assign txd           = line ^ invert;

    tx_word_fifo #(.WIDTH(9), .DEPTH(DEPTH)) i_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .push  (push),
        .din   (wr_data),
        .pop   (load),
        .dout  (head),
        .full  (buf_full),
        .empty (fifo_empty),
        .count (fifo_count)
    );

    tx_frame_shifter #(.TICKS_PER_BIT(TICKS_PER_BIT)) i_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .baud_tick  (baud_tick),
        .load       (load),
        .load_brk   (load_brk),
        .din        (head),
        .nine_bit   (nine_bit),
        .parity_sel (parity_sel),
        .two_stop   (two_stop),
        .busy       (busy),
        .line       (line),
        .finish     (finish),
        .cur_brk    (cur_brk)
    );

    tx_irq_select i_irq (
        .clk               (clk),
        .rst_n             (rst_n),
        .irq_mode          (irq_mode),
        .en_rise           (en_rise),
        .load              (load),
        .load_leaves_empty (leaves_empty),
        .drained           (drained),
        .irq               (tx_irq)
    );

    // Remember the previous enable for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n) en_prev <= 1'b0;
        else        en_prev <= tx_enable;
    end

    // Break request: set by request, cleared by break completion or disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_enable)  brk_flag <= 1'b0;
        else if (brk_set)          brk_flag <= 1'b1;
        else if (finish && cur_brk) brk_flag <= 1'b0;
    end

    assert_disable_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |=> (shifter_empty && !buf_full && !brk_pending));

    assert_idle_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        shifter_empty |-> (txd == !invert));

    assert_full_not_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        shifter_empty |-> !buf_full);

    assert_break_selfclear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && cur_brk && !brk_set) |=> !brk_pending);

    assert_irq_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> $past(load || finish || en_rise));

endmodule

// File: tb/test_uart_break_tx.sv
// Bench for uart_break_tx: sweeps frame formats and data values, fills
// the queue, walks the interrupt modes, sends a break and aborts mid-frame.
module test_uart_break_tx;

    localparam int CLK_PERIOD = 10;
    localparam int BIT_CYC    = 16;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_enable = 1'b0;
    logic       invert = 1'b0;
    logic       nine_bit = 1'b0;
    logic [1:0] parity_sel = 2'b00;
    logic       two_stop = 1'b0;
    logic [1:0] irq_mode = 2'b00;
    logic       brk_set = 1'b0;
    logic       baud_tick = 1'b1;
    logic       wr_valid = 1'b0;
    logic [8:0] wr_data = '0;
    logic       buf_full, shifter_empty, brk_pending, tx_irq, txd;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    bit done = 1'b0;

    uart_break_tx i_uart_break_tx (
        .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .invert(invert),
        .nine_bit(nine_bit), .parity_sel(parity_sel), .two_stop(two_stop),
        .irq_mode(irq_mode), .brk_set(brk_set), .baud_tick(baud_tick),
        .wr_valid(wr_valid), .wr_data(wr_data), .buf_full(buf_full),
        .shifter_empty(shifter_empty), .brk_pending(brk_pending),
        .tx_irq(tx_irq), .txd(txd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Count interrupt pulses at the sampling point.
    always @(negedge clk) if (tx_irq === 1'b1) irq_cnt++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void build(input logic [8:0] d, input bit nine, input logic [1:0] par,
                                  input bit two, output logic [13:0] f, output int n);
        f = '1; f[0] = 1'b0; f[8:1] = d[7:0]; n = 10;
        if (nine)            begin f[9] = d[8];      n = 11; end
        else if (par == 2'b01) begin f[9] = ^d[7:0];  n = 11; end
        else if (par == 2'b10) begin f[9] = ~^d[7:0]; n = 11; end
        if (two) n++;
    endfunction

    // Wait for a start bit, then check every cycle of every bit; leaves the
    // caller at the sample point of the cycle after the last bit.
    task automatic expect_frame(input logic [13:0] f, input int n, input string req,
                                input bit gap_check);
        int gap = 0;
        while (txd === ~invert && gap < 2000) begin
            @(negedge clk);
            gap++;
        end
        if (gap_check) check(gap == 0, "R6 gap", gap, 0);
        for (int b = 0; b < n; b++) begin
            int bad = 0;
            for (int c = 0; c < BIT_CYC; c++) begin
                if (txd !== (f[b] ^ invert)) bad++;
                @(negedge clk);
            end
            check(bad == 0, req, bad, 0);
        end
    endtask

    task automatic write_words(input logic [8:0] w[], input int cnt);
        for (int k = 0; k < cnt; k++) begin
            wr_valid = 1'b1;
            wr_data  = w[k];
            @(negedge clk);
        end
        wr_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int t = 0;
        while (shifter_empty !== 1'b1 && t < 5000) begin @(negedge clk); t++; end
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [13:0] f;
        int          n;
        logic [8:0]  w[];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R3, R10, R2)
        check(txd === 1'b1, "R10 reset idle", txd, 1);
        check(shifter_empty === 1'b1, "R3 reset empty", shifter_empty, 1);
        check(buf_full === 1'b0, "R2 reset full", buf_full, 0);
        check(tx_irq === 1'b0, "R7 reset irq", tx_irq, 0);

        // Enable rise pulse (R8)
        tx_enable = 1'b1;
        @(negedge clk);
        check(tx_irq === 1'b1, "R8 enable pulse", tx_irq, 1);
        @(negedge clk);
        check(tx_irq === 1'b0, "R8 pulse width", tx_irq, 0);

        // Format sweep, 8-bit (R4)
        for (int i = 0; i < 5; i++) begin
            for (int p = 0; p < 4; p++) begin
                for (int s = 0; s < 2; s++) begin
                    logic [8:0] d;
                    d = 9'((i * 83 + 17) % 256);
                    parity_sel = 2'(p);
                    two_stop   = s[0];
                    build(d, 1'b0, 2'(p), s[0], f, n);
                    w = new[1]; w[0] = d;
                    write_words(w, 1);
                    expect_frame(f, n, "R4 format", 1'b0);
                    wait_idle();
                end
            end
        end

        // Nine-bit mode (R5)
        nine_bit = 1'b1;
        parity_sel = 2'b01;
        for (int i = 0; i < 4; i++) begin
            for (int s = 0; s < 2; s++) begin
                logic [8:0] d;
                d = 9'((i * 157 + 40) % 512);
                two_stop = s[0];
                build(d, 1'b1, 2'b01, s[0], f, n);
                w = new[1]; w[0] = d;
                write_words(w, 1);
                expect_frame(f, n, "R5 nine-bit", 1'b0);
                wait_idle();
            end
        end
        nine_bit = 1'b0; parity_sel = 2'b00; two_stop = 1'b0;

        // Burst of six: five held, sixth dropped, back to back (R1, R2, R6)
        w = new[6];
        for (int k = 0; k < 6; k++) w[k] = 9'(8'h11 * (k + 1));
        fork
            begin
                for (int k = 0; k < 6; k++) begin
                    wr_valid = 1'b1; wr_data = w[k];
                    @(negedge clk);
                    if (k == 3) check(buf_full === 1'b0, "R2 three queued", buf_full, 0);
                    if (k == 4) check(buf_full === 1'b1, "R2 four queued", buf_full, 1);
                    if (k == 4) check(shifter_empty === 1'b0, "R3 busy", shifter_empty, 0);
                end
                wr_valid = 1'b0;
            end
            begin
                for (int k = 0; k < 5; k++) begin
                    build(w[k], 1'b0, 2'b00, 1'b0, f, n);
                    expect_frame(f, n, "R6 burst frame", k > 0);
                end
            end
        join
        begin
            int bad = 0;
            for (int c = 0; c < 20 * BIT_CYC; c++) begin
                if (txd !== 1'b1) bad++;
                @(negedge clk);
            end
            check(bad == 0, "R1 sixth word dropped", bad, 0);
            check(shifter_empty === 1'b1, "R3 drained", shifter_empty, 1);
        end

        // Interrupt modes (R7)
        for (int m = 0; m < 4; m++) begin
            int base;
            int exp;
            exp = (m == 0) ? 3 : (m == 3) ? 0 : 1;
            irq_mode = 2'(m);
            @(negedge clk);
            base = irq_cnt;
            w = new[3]; w[0] = 9'h0F0; w[1] = 9'h00F; w[2] = 9'h0C3;
            write_words(w, 3);
            wait_idle();
            check(irq_cnt - base == exp, "R7 irq mode count", irq_cnt - base, exp);
        end
        irq_mode = 2'b00;

        // Break followed by sync word (R9)
        brk_set = 1'b1;
        @(negedge clk);
        brk_set = 1'b0;
        check(brk_pending === 1'b1, "R9 request set", brk_pending, 1);
        w = new[2]; w[0] = 9'h0AB; w[1] = 9'h055;
        fork
            write_words(w, 2);
            begin
                expect_frame(14'h2000, 14, "R9 break bits", 1'b0);
                build(9'h055, 1'b0, 2'b00, 1'b0, f, n);
                expect_frame(f, n, "R9 sync after break", 1'b1);
            end
            begin
                repeat (100) @(negedge clk);
                check(brk_pending === 1'b1, "R9 pending during break", brk_pending, 1);
            end
        join
        check(brk_pending === 1'b0, "R9 self clear", brk_pending, 0);
        wait_idle();

        // Inverted polarity (R10)
        invert = 1'b1;
        @(negedge clk);
        check(txd === 1'b0, "R10 inverted idle", txd, 0);
        build(9'h03A, 1'b0, 2'b10, 1'b1, f, n);
        parity_sel = 2'b10; two_stop = 1'b1;
        w = new[1]; w[0] = 9'h03A;
        write_words(w, 1);
        expect_frame(f, n, "R10 inverted frame", 1'b0);
        wait_idle();
        invert = 1'b0; parity_sel = 2'b00; two_stop = 1'b0;

        // Abort mid-frame (R11), writes while disabled (R1)
        w = new[4]; w[0] = 9'h001; w[1] = 9'h002; w[2] = 9'h003; w[3] = 9'h004;
        write_words(w, 4);
        brk_set = 1'b1;
        @(negedge clk);
        brk_set = 1'b0;
        repeat (40) @(negedge clk);
        check(shifter_empty === 1'b0, "R3 mid frame", shifter_empty, 0);
        tx_enable = 1'b0;
        @(negedge clk);
        check(txd === 1'b1, "R11 line idle", txd, 1);
        check(shifter_empty === 1'b1, "R11 empty", shifter_empty, 1);
        check(buf_full === 1'b0, "R11 not full", buf_full, 0);
        check(brk_pending === 1'b0, "R11 break cleared", brk_pending, 0);
        w = new[1]; w[0] = 9'h0EE;
        write_words(w, 1);
        tx_enable = 1'b1;
        @(negedge clk);
        check(tx_irq === 1'b1, "R8 re-enable pulse", tx_irq, 1);
        begin
            int bad = 0;
            for (int c = 0; c < 14 * BIT_CYC; c++) begin
                if (txd !== 1'b1) bad++;
                @(negedge clk);
            end
            check(bad == 0, "R1 disabled write dropped", bad, 0);
            check(shifter_empty === 1'b1, "R1 nothing queued", shifter_empty, 1);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule